// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Screening

This block receives a bit-serial HDLC stream on a 16 kbit/s signalling channel and turns it into bytes that a processor reads one at a time. Each valid bit arrives with a one-cycle strobe. The receiver looks for the flag pattern to find the start and end of each frame and removes the zeros the sender stuffed into the data. It runs a CRC-16 over each frame and writes the payload bytes into a 19-entry receive FIFO. The last byte of every stored packet carries an end-of-packet tag, and a one-cycle indication fires at the same time.

The receiver can screen packets by address. It compares the upper six bits of the first byte against a programmed value, and it can also compare the whole second byte. A packet that fails is discarded in full. In transparent mode all protocol handling is turned off, and each group of eight sampled bits becomes one byte.

The controller has four states. HUNT waits for a flag. FRAME receives a packet. SKIP discards the rest of a packet that failed the address check. RAW is transparent mode. The transitions are:
- HUNT→FRAME on a flag.
- FRAME→FRAME on a flag (the flag closes one packet and opens the next).
- FRAME→HUNT on an abort.
- FRAME→SKIP on an address mismatch.
- SKIP→FRAME on a flag.
- SKIP→HUNT on an abort.
- Any state→RAW when transparent mode is selected.
- RAW→HUNT when transparent mode is released.

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset the FIFO is empty, `rd_count` is 0, and `pkt_good`, `pkt_badfcs` and `pkt_abort` are low.
- R2: The pattern 01111110 is a flag. It delimits frames and is never stored. One flag can close a packet and open the next. Bits arrive least significant bit first.
- R3: A 0 that follows five consecutive 1s inside a frame is deleted before bytes are assembled.
- R4: The two bytes before the closing flag are the FCS and are never stored. The FCS check uses CRC-16 with polynomial x^16+x^12+x^5+1, bits taken least significant first, preset to all ones, and a required residue of 0xF0B8. When the check passes, the last data byte is stored with tag 2'b01, and `pkt_good` pulses for one cycle.
- R5: When the FCS check fails, or the closing flag does not fall on a byte boundary, the last data byte is stored with tag 2'b10, and `pkt_badfcs` pulses for one cycle.
- R6: A frame with fewer than four bytes between its flags (a data field under 16 bits) stores nothing and raises no indication.
- R7: Seven or more consecutive 1s are an abort. If four or more bytes of the frame were received, the bytes received minus two are stored, the last of them with tag 2'b11, and `pkt_abort` pulses for one cycle. After an abort the receiver waits for a flag.
- R8: With `addr_chk_en` high, bits 7:2 of the first byte must equal `addr_match_hi`; bits 1:0 are not compared. A mismatch discards the whole packet: nothing is stored and no indication fires.
- R9: With `addr_chk_en` and `addr_two` both high, the second byte must also equal `addr_second` in all eight bits. A mismatch discards the packet as in R8.
- R10: In transparent mode there is no flag, abort or stuffing handling. Every strobed bit is shifted in least significant bit first. Each eight bits form one byte with tag 2'b00, counted from entry into the mode. No indication fires.
- R11: The FIFO holds 19 bytes and shows its head byte on `rd_data`/`rd_tag`. `rd_en` removes the head byte. Every byte that is not the last of a packet has tag 2'b00. A byte that arrives while the FIFO is full is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid line bit |
| bit_in | input | 1 | Serial line bit |
| raw_mode | input | 1 | Selects transparent byte assembly |
| addr_chk_en | input | 1 | Enables the address screen |
| addr_two | input | 1 | Also compares the second address byte |
| addr_match_hi | input | 6 | Match value for bits 7:2 of the first byte |
| addr_second | input | 8 | Match value for the second byte |
| rd_en | input | 1 | Removes the head byte from the FIFO |
| rd_data | output | 8 | Head byte of the FIFO |
| rd_tag | output | 2 | Head tag: 00 mid, 01 good, 10 bad FCS, 11 aborted |
| rd_empty | output | 1 | FIFO is empty |
| rd_count | output | 5 | Number of bytes in the FIFO |
| pkt_good | output | 1 | Pulse: packet ended with a good FCS |
| pkt_badfcs | output | 1 | Pulse: packet ended with a bad FCS or misalignment |
| pkt_abort | output | 1 | Pulse: packet ended by an abort |

## Verification
The in-RTL properties check several rules on every cycle:
- A line bit yields at most one of data, flag or abort.
- An abort is reported once per run of 1s.
- Nothing is written while a packet is being skipped.
- A good tag only appears with a passing residue.
- Short frames write nothing.
- The FIFO count stays bounded, and it holds when a byte arrives while full.
- Every aborted write is followed by its pulse.

Only the bench scenarios can show that payload bytes come out in order and with the right values. The same holds for correct zero removal on stuffed data, the CRC arithmetic, which packets the address screen admits or drops, and the exact byte contents and count in transparent mode and at FIFO full.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_RV = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_GOOD    = 16'hF0B8;

    typedef enum logic [1:0] {
        TAG_MID    = 2'b00,
        TAG_GOOD   = 2'b01,
        TAG_BADFCS = 2'b10,
        TAG_ABORT  = 2'b11
    } eop_tag_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FRAME,
        ST_SKIP,
        ST_RAW
    } rx_state_e;

    typedef struct packed {
        eop_tag_e            tag;
        logic [BYTE_W-1:0]   data;
    } fifo_word_t;

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic raw_mode,
    output logic data_ok,
    output logic flag_hit,
    output logic abort_hit
);
    localparam int RUN_W   = 3;
    localparam int STUFF_N = 5;
    localparam int FLAG_N  = 6;
    localparam int RUN_MAX = 7;

    logic [RUN_W-1:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (!bit_in)
                ones_q <= '0;
            else if (ones_q != RUN_W'(RUN_MAX))
                ones_q <= ones_q + RUN_W'(1);
        end
    end

    always_comb begin
        data_ok   = 1'b0;
        flag_hit  = 1'b0;
        abort_hit = 1'b0;
        if (bit_en && !raw_mode) begin
            if (bit_in) begin
                if (ones_q == RUN_W'(FLAG_N))
                    abort_hit = 1'b1;
                else if (ones_q < RUN_W'(FLAG_N))
                    data_ok = 1'b1;
            end else begin
                if (ones_q == RUN_W'(FLAG_N))
                    flag_hit = 1'b1;
                else if (ones_q != RUN_W'(STUFF_N))
                    data_ok = 1'b1;
            end
        end
    end

    // R2, R3: one line bit gives at most one event
    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_ok, flag_hit, abort_hit}) <= 1);

    // R7: a run of ones reports its abort once
    a_r7_abort_once: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> !abort_hit);

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic              crc_ok
);
    logic [CRC_W-1:0] crc_q;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb)
                c = c ^ CRC_POLY_RV;
        end
        return c;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= CRC_PRESET;
        else if (clr)
            crc_q <= CRC_PRESET;
        else if (upd)
            crc_q <= crc_step(crc_q, din);
    end

    assign crc_ok = (crc_q == CRC_GOOD);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter  int DEPTH = 19,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  fifo_word_t wr_word,
    input  logic       rd_en,
    output fifo_word_t rd_word,
    output logic       empty,
    output logic [CW-1:0] count
);
    fifo_word_t     mem [DEPTH];
    logic [AW-1:0]  wp_q, rp_q;
    logic [CW-1:0]  cnt_q;
    logic           full, do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp_q] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= bump(wp_q);
            if (do_rd) rp_q <= bump(rp_q);
            if (do_wr && !do_rd)
                cnt_q <= cnt_q + CW'(1);
            else if (do_rd && !do_wr)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    assign rd_word = mem[rp_q];
    assign count   = cnt_q;

    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    a_r11_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(cnt_q));

    a_r11_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
    import hdlc_rx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 19,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             raw_mode,
    input  logic             addr_chk_en,
    input  logic             addr_two,
    input  logic [5:0]       addr_match_hi,
    input  logic [7:0]       addr_second,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [1:0]       rd_tag,
    output logic             rd_empty,
    output logic [CNT_W-1:0] rd_count,
    output logic             pkt_good,
    output logic             pkt_badfcs,
    output logic             pkt_abort
);
    localparam int FCS_BYTES  = CRC_W / BYTE_W;
    localparam int HOLD_DEPTH = FCS_BYTES + 1;
    localparam int NBW        = $clog2(HOLD_DEPTH + 2);
    localparam logic [NBW-1:0] LIVE = NBW'(HOLD_DEPTH + 1);
    localparam int BCW        = $clog2(BYTE_W);

    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] asm_q;
    logic [BCW-1:0]    bcnt_q;
    logic [NBW-1:0]    nbytes_q;
    logic [BYTE_W-1:0] hold_q [HOLD_DEPTH];

    logic              data_ok, flag_hit, abort_hit;
    logic              crc_ok, bit_take, byte_done, addr_miss;
    logic [BYTE_W-1:0] new_byte;
    logic              wr_en;
    fifo_word_t        wr_word, rd_word;

    hdlc_rx_deframer u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .raw_mode  (state_q == ST_RAW),
        .data_ok   (data_ok),
        .flag_hit  (flag_hit),
        .abort_hit (abort_hit)
    );

    assign bit_take  = (state_q == ST_FRAME && data_ok) || (state_q == ST_RAW && bit_en);
    assign byte_done = bit_take && (bcnt_q == BCW'(BYTE_W - 1));
    assign new_byte  = {bit_in, asm_q[BYTE_W-1:1]};

    hdlc_rx_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flag_hit || abort_hit || state_q == ST_HUNT),
        .upd    (byte_done && state_q == ST_FRAME),
        .din    (new_byte),
        .crc_ok (crc_ok)
    );

    always_comb begin
        addr_miss = 1'b0;
        if (byte_done && state_q == ST_FRAME && addr_chk_en) begin
            if (nbytes_q == NBW'(0) && new_byte[7:2] != addr_match_hi)
                addr_miss = 1'b1;
            if (nbytes_q == NBW'(1) && addr_two && new_byte != addr_second)
                addr_miss = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (raw_mode)      state_d = ST_RAW;
                else if (flag_hit) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (raw_mode)       state_d = ST_RAW;
                else if (abort_hit) state_d = ST_HUNT;
                else if (addr_miss) state_d = ST_SKIP;
            end
            ST_SKIP: begin
                if (raw_mode)       state_d = ST_RAW;
                else if (flag_hit)  state_d = ST_FRAME;
                else if (abort_hit) state_d = ST_HUNT;
            end
            ST_RAW: begin
                if (!raw_mode)      state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // FIFO write decisions
    always_comb begin
        wr_en        = 1'b0;
        wr_word.tag  = TAG_MID;
        wr_word.data = hold_q[0];
        unique case (state_q)
            ST_FRAME: begin
                if (flag_hit && nbytes_q == LIVE) begin
                    wr_en       = 1'b1;
                    wr_word.tag = (bcnt_q == BCW'(BYTE_W - 1) && crc_ok) ? TAG_GOOD : TAG_BADFCS;
                end else if (abort_hit && nbytes_q == LIVE) begin
                    wr_en       = 1'b1;
                    wr_word.tag = TAG_ABORT;
                end else if (byte_done && !addr_miss && nbytes_q >= NBW'(HOLD_DEPTH)) begin
                    wr_en       = 1'b1;
                end
            end
            ST_RAW: begin
                if (byte_done) begin
                    wr_en        = 1'b1;
                    wr_word.data = new_byte;
                end
            end
            default: ;
        endcase
    end

    // byte assembly and hold line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q    <= '0;
            bcnt_q   <= '0;
            nbytes_q <= '0;
            for (int i = 0; i < HOLD_DEPTH; i++)
                hold_q[i] <= '0;
        end else if (state_q != ST_RAW && state_d == ST_RAW) begin
            bcnt_q   <= '0;
            nbytes_q <= '0;
        end else if (flag_hit || abort_hit) begin
            bcnt_q   <= '0;
            nbytes_q <= '0;
        end else if (bit_take) begin
            asm_q  <= new_byte;
            bcnt_q <= bcnt_q + BCW'(1);
            if (byte_done && state_q == ST_FRAME && !addr_miss) begin
                if (nbytes_q < NBW'(HOLD_DEPTH)) begin
                    for (int i = 0; i < HOLD_DEPTH; i++)
                        if (nbytes_q == NBW'(i))
                            hold_q[i] <= new_byte;
                    nbytes_q <= nbytes_q + NBW'(1);
                end else begin
                    for (int i = 0; i < HOLD_DEPTH - 1; i++)
                        hold_q[i] <= hold_q[i+1];
                    hold_q[HOLD_DEPTH-1] <= new_byte;
                    nbytes_q <= LIVE;
                end
            end
        end
    end

    // indications
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_good   <= 1'b0;
            pkt_badfcs <= 1'b0;
            pkt_abort  <= 1'b0;
        end else begin
            pkt_good   <= wr_en && wr_word.tag == TAG_GOOD;
            pkt_badfcs <= wr_en && wr_word.tag == TAG_BADFCS;
            pkt_abort  <= wr_en && wr_word.tag == TAG_ABORT;
        end
    end

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .empty   (rd_empty),
        .count   (rd_count)
    );

    assign rd_data = rd_word.data;
    assign rd_tag  = rd_word.tag;

    a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !wr_en);

    a_r4_good_needs_residue: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word.tag == TAG_GOOD) |-> crc_ok);

    a_r6_short_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hit && nbytes_q != LIVE) |-> !wr_en);

    a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word.tag == TAG_ABORT) |=> pkt_abort);

    a_r10_raw_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAW) |-> !(pkt_good || pkt_badfcs || pkt_abort) || $past(state_q) != ST_RAW);

endmodule

// File: tb/hdlc_addr_rx_tb_top.sv
module hdlc_addr_rx_tb_top;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0, raw_mode = 1'b0;
    logic       addr_chk_en = 1'b0, addr_two = 1'b0;
    logic [5:0] addr_match_hi = '0;
    logic [7:0] addr_second = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic       rd_empty;
    logic [4:0] rd_count;
    logic       pkt_good, pkt_badfcs, pkt_abort;

    int n_checks = 0, n_fail = 0;
    int seen_good = 0, seen_bad = 0, seen_abort = 0;
    int exp_good = 0, exp_bad = 0, exp_abort = 0;
    int tx_ones = 0;

    always #4 clk = ~clk;

    hdlc_addr_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .raw_mode(raw_mode), .addr_chk_en(addr_chk_en), .addr_two(addr_two),
        .addr_match_hi(addr_match_hi), .addr_second(addr_second),
        .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rd_empty(rd_empty),
        .rd_count(rd_count), .pkt_good(pkt_good), .pkt_badfcs(pkt_badfcs),
        .pkt_abort(pkt_abort)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            seen_good  <= seen_good  + int'(pkt_good);
            seen_bad   <= seen_bad   + int'(pkt_badfcs);
            seen_abort <= seen_abort + int'(pkt_abort);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_of(input bq_t q);
        logic [15:0] c = 16'hFFFF;
        logic        fb;
        foreach (q[i]) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ q[i][j];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    task automatic send_raw_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_raw_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_raw_bit(b[i]);
    endtask

    task automatic send_flag();
        send_raw_byte(8'h7E);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        send_raw_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_data_bit(b[i]);
    endtask

    // body, FCS and closing flag; opening flag is optional
    task automatic send_frame(input bq_t q, input bit corrupt, input bit open_flag);
        logic [15:0] f;
        if (open_flag) send_flag();
        foreach (q[i]) send_byte(q[i]);
        f = fcs_of(q);
        if (corrupt) f = f ^ 16'h0100;
        send_byte(f[7:0]);
        send_byte(f[15:8]);
        send_flag();
    endtask

    task automatic expect_bytes(input bq_t q, input logic [1:0] last_tag, input string req);
        logic [1:0] et;
        repeat (3) @(negedge clk);
        if (last_tag == 2'b01) exp_good++;
        if (last_tag == 2'b10) exp_bad++;
        if (last_tag == 2'b11) exp_abort++;
        chk(int'(rd_count) == q.size(), req, "fifo count", int'(rd_count), q.size());
        chk(seen_good == exp_good, req, "good pulses", seen_good, exp_good);
        chk(seen_bad == exp_bad, req, "badfcs pulses", seen_bad, exp_bad);
        chk(seen_abort == exp_abort, req, "abort pulses", seen_abort, exp_abort);
        foreach (q[i]) begin
            et = (i == q.size() - 1) ? last_tag : 2'b00;
            if (rd_empty) begin
                chk(1'b0, req, "fifo empty early", i, q.size());
                break;
            end
            chk(rd_data == q[i], req, "data", int'(rd_data), int'(q[i]));
            chk(rd_tag == et, req, "tag", int'(rd_tag), int'(et));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(rd_empty == 1'b1, req, "empty after drain", int'(rd_empty), 1);
    endtask

    function automatic bq_t rand_bytes(input int n);
        bq_t q;
        for (int i = 0; i < n; i++) begin
            if ($urandom % 5 == 0) q.push_back(8'hFF);
            else q.push_back(8'($urandom));
        end
        return q;
    endfunction

    initial begin
        bq_t q, e;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        // R1: reset state
        chk(rd_empty == 1'b1, "R1", "empty", int'(rd_empty), 1);
        chk(rd_count == 5'd0, "R1", "count", int'(rd_count), 0);
        chk({pkt_good, pkt_badfcs, pkt_abort} == 3'b000, "R1", "indications",
            int'({pkt_good, pkt_badfcs, pkt_abort}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3, R4: directed stuffing-heavy packet
        q = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
        send_frame(q, 1'b0, 1'b1);
        expect_bytes(q, 2'b01, "R3_R4");

        // R2, R4: random packets sharing flags
        for (int k = 0; k < 8; k++) begin
            q = rand_bytes(2 + int'($urandom % 13));
            send_frame(q, 1'b0, 1'b0);
            expect_bytes(q, 2'b01, "R2_R4");
        end

        // R4: minimum-size packet (two data bytes)
        q = '{8'h12, 8'h34};
        send_frame(q, 1'b0, 1'b0);
        expect_bytes(q, 2'b01, "R4");

        // R5: corrupted FCS
        q = rand_bytes(6);
        send_frame(q, 1'b1, 1'b0);
        expect_bytes(q, 2'b10, "R5");

        // R6: one data byte is too short
        q = '{8'hA5};
        send_frame(q, 1'b0, 1'b0);
        e = {};
        expect_bytes(e, 2'b00, "R6");

        // R7: abort after six bytes
        q = rand_bytes(6);
        foreach (q[i]) send_byte(q[i]);
        repeat (7) send_raw_bit(1'b1);
        tx_ones = 0;
        e = q[0:3];
        expect_bytes(e, 2'b11, "R7");
        send_flag();

        // R8: one-byte screen
        addr_chk_en   = 1'b1;
        addr_match_hi = 6'b101001;
        q = '{8'hA7, 8'h01, 8'h02};
        send_frame(q, 1'b0, 1'b0);
        expect_bytes(q, 2'b01, "R8");
        q = '{8'h24, 8'h01, 8'h02};
        send_frame(q, 1'b0, 1'b0);
        e = {};
        expect_bytes(e, 2'b00, "R8");

        // R9: two-byte screen
        addr_two    = 1'b1;
        addr_second = 8'h5C;
        q = '{8'hA5, 8'h5C, 8'h99, 8'h10};
        send_frame(q, 1'b0, 1'b0);
        expect_bytes(q, 2'b01, "R9");
        q = '{8'hA4, 8'h5D, 8'h99, 8'h10};
        send_frame(q, 1'b0, 1'b0);
        e = {};
        expect_bytes(e, 2'b00, "R9");
        addr_chk_en = 1'b0;
        addr_two    = 1'b0;

        // R10: transparent assembly with flag and abort patterns
        @(negedge clk);
        raw_mode = 1'b1;
        repeat (3) @(negedge clk);
        q = '{8'h7E, 8'hFF, 8'h00, 8'hFE};
        q.push_back(8'($urandom));
        foreach (q[i]) send_raw_byte(q[i]);
        expect_bytes(q, 2'b00, "R10");

        // R11: FIFO full drops later bytes
        q = rand_bytes(21);
        foreach (q[i]) send_raw_byte(q[i]);
        e = q[0:18];
        expect_bytes(e, 2'b00, "R11");

        raw_mode = 1'b0;
        repeat (3) @(negedge clk);

        // R2: framing resumes after transparent mode
        q = rand_bytes(5);
        send_frame(q, 1'b0, 1'b1);
        expect_bytes(q, 2'b01, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule